// File: doc/BRIEF.md
# Programmable-Balance Three-Lane Deserializer

This block turns three serial data lanes, sampled once per bit-clock cycle, into one 21-bit parallel word per frame. A frame marker, derived from the recovered parallel clock, is high in the cycle that carries bit 0 of a frame. A mode input picks one of two framings. In plain framing every lane carries 7 payload bits per frame. In balanced framing every lane carries 9 bits: the 7 payload bits followed by a two-bit polarity flag. The flag tells the block whether the sender inverted that group to keep the line DC-balanced. The block undoes that inversion before it presents the word.

Around the data path the block also handles the output side of the link. In plain framing it forces a silent data lane, or the whole word, to zero when the lane or the frame marker stops toggling. It drives an output enable that power-down clears. It produces an output strobe whose active edge, rising or falling as configured, arrives while the word is stable.

Top module: `dcb_deser`

## Requirements
- R1: After reset, word_o, valid_o and err_o are all zero, and pclk_o is low when fall_sel_i is low.
- R2: In plain framing each lane delivers 7 bits, least significant first, starting in the cycle where frame_i is high. Lane k fills word_o[7k+6:7k]. word_o updates, and valid_o pulses high for exactly one cycle, on the clock edge that follows the edge capturing the last bit. word_o holds its value between pulses.
- R3: In balanced framing each lane delivers 9 bits. Bits 0 to 6 are payload and bits 7 and 8 form the flag {bit8,bit7}. Flag 2'b01 means true polarity, and the payload is output as received.
- R4: A lane whose flag is 2'b10 was sent inverted, so its 7 payload bits are output complemented.
- R5: A lane whose flag is 2'b00 or 2'b11 sets its err_o bit (err_o[k] for lane k) for that word and outputs its payload unchanged. In plain framing err_o stays zero. err_o changes only together with a valid_o pulse.
- R6: balanced_i is sampled only in the cycle that carries bit 0 of a frame. A change later in the frame does not alter the length or the decoding of that frame.
- R7: frame_i restarts the bit count at bit 0 whatever the count was, so a partial frame is discarded and the next complete frame decodes correctly.
- R8: oe_o is low whenever pwr_ni is low, and high whenever pwr_ni is high.
- R9: In plain framing, a data lane that shows no transition across 4 complete frames outputs zeros in its 7 bits, starting with the fourth such frame. It returns to normal on the first frame that contains a transition.
- R10: In plain framing, if frame_i stays low for 36 bit-clock cycles, word_o reads all zeros and no valid_o pulse occurs until frame_i returns.
- R11: pclk_o makes its active edge one cycle after the valid_o pulse, while word_o is unchanged. The active edge is rising when fall_sel_i is low and falling when fall_sel_i is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | High in the cycle carrying bit 0 of a frame |
| balanced_i | input | 1 | 1 selects 9-bit balanced framing, 0 selects 7-bit plain framing |
| lane_i | input | 3 | One serial bit per lane per cycle |
| pwr_ni | input | 1 | Power-down, active low |
| fall_sel_i | input | 1 | 1 makes the strobe's active edge falling |
| word_o | output | 21 | Decoded parallel word |
| valid_o | output | 1 | One-cycle pulse when word_o updates |
| err_o | output | 3 | Per-lane invalid polarity flag |
| pclk_o | output | 1 | Output strobe |
| oe_o | output | 1 | Output enable, low in power-down |

## Verification
The bench covers all four flag codes, and it covers lanes that use different codes within the same word. A design that read the flag bits in the wrong order would swap true and inverted data. One that decoded the invalid codes would corrupt the payload instead of flagging it. It flips the mode in the middle of a frame and sends a truncated frame before a marker. A design that latched the mode every cycle, or ignored the marker, would take the wrong number of bits and shift the word. It holds one lane constant for five frames and then stops the marker altogether. An off-by-one idle counter would blank the lane a frame early or late, or would fail to recover on the first frame with a transition. It checks the strobe in both polarities one cycle after the valid pulse, which catches a strobe aligned with the update instead of after it.

// File: rtl/dcb_deser_pkg.sv
package dcb_deser_pkg;
   // Number of polarity-flag bits appended per lane in balanced framing.
   localparam int FLAG_W = 2;

   // Flag field {bit8,bit7}; only the two complementary codes are legal.
   typedef enum logic [FLAG_W-1:0] {
      FL_LOW  = 2'b00,
      FL_TRUE = 2'b01,
      FL_INV  = 2'b10,
      FL_HIGH = 2'b11
   } flag_e;
endpackage

// File: rtl/dcb_frame_ctl.sv
module dcb_frame_ctl import dcb_deser_pkg::*; #(
   parameter int PAY_W    = 7,
   parameter int LOSS_CYC = 36,
   localparam int FRAME_MAX = PAY_W + FLAG_W,
   localparam int IW = $clog2(FRAME_MAX),
   localparam int GW = $clog2(LOSS_CYC + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          frame_i,
   input  logic          bal_i,
   output logic [IW-1:0] idx_o,
   output logic          cap_o,
   output logic          fend_o,
   output logic          mode_o,
   output logic          done_o,
   output logic          lost_o
);
   logic [IW-1:0] idx_q, cur;
   logic          mode_q, locked_q, done_q, lost_q, eff, last;
   logic [GW-1:0] gap_q;

   // R7: the marker forces the current bit to index 0
   assign cur  = frame_i ? '0 : idx_q;
   // R6: mode is taken from the input only at bit 0
   assign eff  = (cur == '0) ? bal_i : mode_q;
   assign last = (cur == (eff ? IW'(FRAME_MAX - 1) : IW'(PAY_W - 1)));
   assign cap_o  = locked_q | frame_i;
   assign fend_o = cap_o & last;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idx_q    <= '0;
         mode_q   <= 1'b0;
         locked_q <= 1'b0;
         done_q   <= 1'b0;
         lost_q   <= 1'b0;
         gap_q    <= '0;
      end else begin
         idx_q    <= last ? '0 : cur + IW'(1);
         if (cur == '0) mode_q <= bal_i;
         locked_q <= cap_o;
         done_q   <= fend_o & ~lost_q;
         // R10: marker silence measured in bit-clock cycles
         if (frame_i) begin
            gap_q  <= '0;
            lost_q <= 1'b0;
         end else if (gap_q == GW'(LOSS_CYC - 1)) begin
            lost_q <= 1'b1;
         end else begin
            gap_q  <= gap_q + GW'(1);
         end
      end
   end

   assign idx_o  = cur;
   assign mode_o = mode_q;
   assign done_o = done_q;
   assign lost_o = lost_q;
endmodule

// File: rtl/dcb_lane.sv
module dcb_lane import dcb_deser_pkg::*; #(
   parameter int PAY_W       = 7,
   parameter int IDLE_FRAMES = 4,
   localparam int FRAME_MAX = PAY_W + FLAG_W,
   localparam int IW = $clog2(FRAME_MAX),
   localparam int CW = $clog2(IDLE_FRAMES + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             bit_i,
   input  logic             cap_i,
   input  logic [IW-1:0]    idx_i,
   input  logic             fend_i,
   input  logic             bal_i,
   output logic [PAY_W-1:0] pay_o,
   output logic             err_o,
   output logic             idle_o
);
   logic [FRAME_MAX-1:0] buf_q;
   logic                 prev_q, tr_q, idle_q, chg;
   logic [CW-1:0]        cnt_q;
   flag_e                fl;

   assign chg = bit_i ^ prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         buf_q  <= '0;
         prev_q <= 1'b0;
         tr_q   <= 1'b0;
         cnt_q  <= '0;
         idle_q <= 1'b0;
      end else if (cap_i) begin
         // R2: index-addressed capture, bit 0 first
         for (int b = 0; b < FRAME_MAX; b++) begin
            if (idx_i == IW'(b)) buf_q[b] <= bit_i;
         end
         prev_q <= bit_i;
         tr_q   <= (idx_i == '0) ? chg : (tr_q | chg);
         // R9: count whole frames without a transition
         if (fend_i) begin
            if (tr_q | chg) begin
               cnt_q  <= '0;
               idle_q <= 1'b0;
            end else if (cnt_q == CW'(IDLE_FRAMES - 1)) begin
               idle_q <= 1'b1;
            end else begin
               cnt_q  <= cnt_q + CW'(1);
            end
         end
      end
   end

   // R3 R4 R5: polarity restore from the flag field
   assign fl     = flag_e'(buf_q[FRAME_MAX-1:PAY_W]);
   assign pay_o  = (bal_i && fl == FL_INV) ? ~buf_q[PAY_W-1:0] : buf_q[PAY_W-1:0];
   assign err_o  = bal_i && (fl == FL_LOW || fl == FL_HIGH);
   assign idle_o = idle_q;
endmodule

// File: rtl/dcb_deser.sv
module dcb_deser import dcb_deser_pkg::*; #(
   parameter int LANES       = 3,
   parameter int PAY_W       = 7,
   parameter int IDLE_FRAMES = 4,
   parameter int LOSS_CYC    = IDLE_FRAMES * (PAY_W + FLAG_W)
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   frame_i,
   input  logic                   balanced_i,
   input  logic [LANES-1:0]       lane_i,
   input  logic                   pwr_ni,
   input  logic                   fall_sel_i,
   output logic [LANES*PAY_W-1:0] word_o,
   output logic                   valid_o,
   output logic [LANES-1:0]       err_o,
   output logic                   pclk_o,
   output logic                   oe_o
);
   localparam int FRAME_MAX = PAY_W + FLAG_W;
   localparam int IW = $clog2(FRAME_MAX);

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (PAY_W < 2) begin : g_bad_pay
      $error("PAY_W must be at least 2");
   end
   if (IDLE_FRAMES < 1) begin : g_bad_idle
      $error("IDLE_FRAMES must be at least 1");
   end
   if (LOSS_CYC < FRAME_MAX) begin : g_bad_loss
      $error("LOSS_CYC must cover a full balanced frame");
   end

   logic [IW-1:0]                idx;
   logic                         cap, fend, mode, done, lost;
   logic [LANES-1:0][PAY_W-1:0]  pay, kept;
   logic [LANES-1:0]             lerr, idle;
   logic [LANES*PAY_W-1:0]       word_q;
   logic [LANES-1:0]             err_q;
   logic                         valid_q, stb_q, zero_all;

   dcb_frame_ctl #(.PAY_W(PAY_W), .LOSS_CYC(LOSS_CYC)) u_ctl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .frame_i(frame_i),
      .bal_i  (balanced_i),
      .idx_o  (idx),
      .cap_o  (cap),
      .fend_o (fend),
      .mode_o (mode),
      .done_o (done),
      .lost_o (lost)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dcb_lane #(.PAY_W(PAY_W), .IDLE_FRAMES(IDLE_FRAMES)) u_lane (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .bit_i (lane_i[g]),
         .cap_i (cap),
         .idx_i (idx),
         .fend_i(fend),
         .bal_i (mode),
         .pay_o (pay[g]),
         .err_o (lerr[g]),
         .idle_o(idle[g])
      );
      // R9: idle blanking applies to plain framing only
      assign kept[g] = (idle[g] & ~mode) ? '0 : pay[g];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_q  <= '0;
         err_q   <= '0;
         valid_q <= 1'b0;
         stb_q   <= 1'b0;
      end else begin
         valid_q <= done;
         stb_q   <= valid_q;
         if (done) begin
            word_q <= kept;
            err_q  <= lerr;
         end
      end
   end

   // R10: marker loss blanks the whole word in plain framing
   assign zero_all = lost & ~mode;
   assign word_o   = zero_all ? '0 : word_q;
   assign valid_o  = valid_q;
   assign err_o    = err_q;
   // R11: strobe one cycle behind the update, polarity selectable
   assign pclk_o   = stb_q ^ fall_sel_i;
   // R8
   assign oe_o     = pwr_ni;
endmodule

// File: rtl/dcb_deser_chk.sv
module dcb_deser_chk #(
   parameter int W     = 21,
   parameter int LANES = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             valid_o,
   input logic [LANES-1:0] err_o,
   input logic [W-1:0]     word_o,
   input logic             pclk_o,
   input logic             fall_sel_i,
   input logic             zero_all
);
   assert_valid_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);

   assert_word_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_o && $stable(zero_all)) |-> $stable(word_o));

   assert_err_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> $stable(err_o));

   assert_rise_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(pclk_o) && !fall_sel_i && $stable(fall_sel_i) && $stable(zero_all))
      |-> $stable(word_o));

   assert_fall_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(pclk_o) && fall_sel_i && $stable(fall_sel_i) && $stable(zero_all))
      |-> $stable(word_o));
endmodule

bind dcb_deser dcb_deser_chk #(.W(LANES*PAY_W), .LANES(LANES)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .valid_o   (valid_o),
   .err_o     (err_o),
   .word_o    (word_o),
   .pclk_o    (pclk_o),
   .fall_sel_i(fall_sel_i),
   .zero_all  (zero_all)
);

// File: tb/dcb_deser_test.sv
module dcb_deser_test;
   logic        clk = 1'b0;
   logic        rst_ni, frame_i, balanced_i, pwr_ni, fall_sel_i;
   logic [2:0]  lane_i;
   logic [20:0] word_o;
   logic        valid_o, pclk_o, oe_o;
   logic [2:0]  err_o;

   always #2.5 clk = ~clk;

   dcb_deser uut (
      .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i), .balanced_i(balanced_i),
      .lane_i(lane_i), .pwr_ni(pwr_ni), .fall_sel_i(fall_sel_i),
      .word_o(word_o), .valid_o(valid_o), .err_o(err_o), .pclk_o(pclk_o), .oe_o(oe_o)
   );

   int tests = 0;
   int fails = 0;
   logic        prev_b [3];
   int          cnt_b  [3];
   bit          idle_b [3];
   logic [20:0] exp_w;
   logic [2:0]  exp_e;

   localparam bit         VBAL [8] = '{0, 1, 1, 1, 0, 1, 0, 1};
   localparam logic [8:0] VL0  [8] = '{9'h055, 9'h0B5, 9'h135, 9'h02D, 9'h07F, 9'h100, 9'h001, 9'h0AA};
   localparam logic [8:0] VL1  [8] = '{9'h02A, 9'h0CC, 9'h10F, 9'h1DA, 9'h000, 9'h0FF, 9'h040, 9'h155};
   localparam logic [8:0] VL2  [8] = '{9'h013, 9'h081, 9'h0F0, 9'h166, 9'h06B, 9'h1BC, 9'h03E, 9'h011};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected word from the requirements: R2..R5 decode, R9 idle blanking.
   task automatic model(input bit bal, input logic [8:0] a, input logic [8:0] b, input logic [8:0] c);
      logic [8:0] ln [3];
      int n;
      ln[0] = a; ln[1] = b; ln[2] = c;
      n = bal ? 9 : 7;
      for (int k = 0; k < 3; k++) begin
         bit tr = 0;
         logic p = prev_b[k];
         logic [6:0] pay;
         logic [1:0] f;
         for (int i = 0; i < n; i++) begin
            if (ln[k][i] !== p) tr = 1;
            p = ln[k][i];
         end
         prev_b[k] = p;
         if (tr) begin cnt_b[k] = 0; idle_b[k] = 0; end
         else if (cnt_b[k] == 3) idle_b[k] = 1;
         else cnt_b[k]++;
         pay = ln[k][6:0];
         f   = {ln[k][8], ln[k][7]};
         exp_e[k] = 1'b0;
         if (bal) begin
            if (f == 2'b10) pay = ~pay;
            exp_e[k] = (f == 2'b00 || f == 2'b11);
         end else if (idle_b[k]) begin
            pay = '0;
         end
         exp_w[k*7 +: 7] = pay;
      end
   endtask

   // Drives one frame, then two hold cycles; returns one cycle after the update.
   task automatic send(input bit bal, input logic [8:0] a, input logic [8:0] b,
                       input logic [8:0] c, input int flip);
      int n;
      n = bal ? 9 : 7;
      model(bal, a, b, c);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frame_i    = (i == 0);
         balanced_i = (flip >= 0 && i >= flip) ? ~bal : bal;
         lane_i     = {c[i], b[i], a[i]};
      end
      @(negedge clk);
      frame_i = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #500us;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst_ni = 0; frame_i = 0; balanced_i = 0; lane_i = '0; pwr_ni = 1; fall_sel_i = 0;
      for (int k = 0; k < 3; k++) begin prev_b[k] = 0; cnt_b[k] = 0; idle_b[k] = 0; end
      repeat (3) @(negedge clk);
      rst_ni = 1;
      @(negedge clk);
      chk("R1 word", word_o, 0);
      chk("R1 valid", valid_o, 0);
      chk("R1 err", err_o, 0);
      chk("R1 pclk", pclk_o, 0);

      // Table walk: plain (R2) and balanced with all flag codes (R3 R4 R5)
      for (int v = 0; v < 8; v++) begin
         send(VBAL[v], VL0[v], VL1[v], VL2[v], -1);
         if (VBAL[v]) begin
            chk("R3 R4 balanced word", word_o, exp_w);
            chk("R5 err flags", err_o, exp_e);
         end else begin
            chk("R2 plain word", word_o, exp_w);
            chk("R5 err in plain", err_o, 0);
         end
         chk("R2 valid pulse", valid_o, 1);
         @(negedge clk);
         chk("R2 valid single", valid_o, 0);
         chk("R2 word held", word_o, exp_w);
      end

      // R11: rising strobe one cycle after the update
      send(0, 9'h033, 9'h05A, 9'h01C, -1);
      chk("R11 rise pre", pclk_o, 0);
      @(negedge clk);
      chk("R11 rise edge", pclk_o, 1);
      chk("R11 word at edge", word_o, exp_w);
      fall_sel_i = 1;
      send(1, 9'h0B1, 9'h14E, 9'h09C, -1);
      chk("R11 fall pre", pclk_o, 1);
      @(negedge clk);
      chk("R11 fall edge", pclk_o, 0);
      chk("R11 word at fall", word_o, exp_w);
      fall_sel_i = 0;

      // R6: mode flip mid-frame is ignored
      send(1, 9'h12B, 9'h0D4, 9'h16A, 3);
      chk("R6 balanced kept", word_o, exp_w);
      send(0, 9'h065, 9'h01A, 9'h04C, 2);
      chk("R6 plain kept", word_o, exp_w);

      // R7: partial frame then a marker restarts the count
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         frame_i = (i == 0); balanced_i = 0;
         lane_i = (i == 1) ? 3'b000 : 3'b111;
         for (int k = 0; k < 3; k++) prev_b[k] = lane_i[k];
      end
      send(0, 9'h05D, 9'h026, 9'h071, -1);
      chk("R7 resync word", word_o, exp_w);

      // R8: power-down clears the output enable
      pwr_ni = 0; #1;
      chk("R8 oe off", oe_o, 0);
      pwr_ni = 1; #1;
      chk("R8 oe on", oe_o, 1);

      // R9: lane 1 constant high for five plain frames, then recovers
      for (int f = 0; f < 5; f++) begin
         send(0, 9'h055, 9'h07F, 9'h02A, -1);
         chk("R9 idle sequence", word_o, exp_w);
      end
      chk("R9 lane blanked", word_o[13:7], 0);
      chk("R9 other lanes", {word_o[20:14], word_o[6:0]}, {7'h2A, 7'h55});
      send(0, 9'h055, 9'h015, 9'h02A, -1);
      chk("R9 recovered", word_o[13:7], 7'h15);

      // R10: marker stops in plain framing
      @(negedge clk);
      frame_i = 0; balanced_i = 0;
      repeat (60) @(negedge clk);
      chk("R10 word blanked", word_o, 0);
      repeat (9) begin
         @(negedge clk);
         chk("R10 no valid", valid_o, 0);
      end
      send(0, 9'h055, 9'h02A, 9'h035, -1);
      chk("R10 recovered", word_o, {7'h35, 7'h2A, 7'h55});

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule